// File: doc/BRIEF.md
# Multi-Pool Bus Priority Arbiter

This block decides which of four bus masters may use one slave port. Each master has a 2-bit priority level for this slave, supplied on a plain input port. The arbiter evaluates the request vector only on a cycle where the arbitration-point strobe is high. On the next clock it registers a one-hot grant, which then holds until the next arbitration point. A higher level always beats a lower one. Level 0 (the bottom pool) and level 3 (the top pool) share the bus round-robin, and each keeps its own rotation pointer. Levels 1 and 2 are fixed-priority pools in which the lower master index wins.

Fairness is enforced across all levels. When two or more masters request at an arbitration point, the master holding the current grant is left out, whatever its level. A master can therefore keep the bus back to back only while it is the only requester. After reset every level input is expected at 0, which gives plain round-robin across all four masters.

A small two-state machine tracks whether the port is owned:
- ST_IDLE: no grant is held.
- ST_OWNED: one master holds the grant.

Its transitions are:
- IDLE_TO_OWNED: an arbitration point with at least one request.
- OWNED_TO_IDLE: an arbitration point with no request.
- OWNED_REARB: an arbitration point with requests present, so the grant is re-decided.
- IDLE_STAY: no winner, or no arbitration point.

Top module: `prio_pool_arbiter`

## Requirements
- R1: The grant is all zeros after reset, and at every cycle it has at most one bit set.
- R2: The grant changes only on the clock edge that samples arb_point high; on every other edge it holds its value.
- R3: A grant goes only to a master whose req bit was high at the arbitration point. With req all zero at an arbitration point, the grant becomes all zeros.
- R4: Among eligible requesters, one with a numerically higher level is always chosen over one with a lower level.
- R5: Level 0 pool rotates. The winner is the first eligible level-0 requester after the last level-0 winner, in ascending cyclic index order (0,1,2,3,0...). After reset the search starts at master 0. The pool's pointer moves only when a level-0 master wins.
- R6: Level 3 pool rotates in the same way as R5, with its own pointer that moves only when a level-3 master wins.
- R7: In levels 1 and 2, the eligible requester with the lowest index wins.
- R8: When two or more req bits are high at an arbitration point, the master currently granted is not granted again.
- R9: A master that is the only requester at an arbitration point keeps or receives the grant, including back to back.
- R10: Each master's level is taken from level_vec (bits [2i+1:2i] for master i) only on the edge that samples arb_point. Level changes between arbitration points have no effect until then.
- R11: Under continuous requests with an arbitration point every cycle, a requesting level-3 master is granted within k arbitration points, where k is the number of requesting level-3 masters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Request bit per master |
| level_vec | input | 8 | Priority level per master, 2 bits each, master i at [2i+1:2i] |
| arb_point | input | 1 | High on a cycle where a new decision is taken |
| grant | output | 4 | Registered one-hot grant, zero when idle |

## Verification
The arbitration decision has exactly one cycle of latency. Inputs sampled on the edge where arb_point is high show up on grant just after that same edge, and nothing changes on any other edge. The bench drives inputs at the falling edge, then compares grant at the following falling edge with a behavioural model that was advanced by that one decision. This places every comparison half a cycle clear of the edge that produces the result. The R11 latency bound is counted in arbitration points by a separate per-master wait counter in the bench.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int ARB_MASTERS = 4;
    localparam int ARB_LVL_W   = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } arb_state_t;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last) + k) % N;
            if (!found && cand[j]) begin
                found = 1'b1;
                idx   = j[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = 0; j < N; j++) begin
            if (!found && cand[j]) begin
                found = 1'b1;
                idx   = j[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/prio_pool_arbiter.sv
module prio_pool_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_M = ARB_MASTERS,
    parameter int LVL_W = ARB_LVL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_M-1:0]       req,
    input  logic [NUM_M*LVL_W-1:0] level_vec,
    input  logic                   arb_point,
    output logic [NUM_M-1:0]       grant
);
    localparam int IW      = (NUM_M > 1) ? $clog2(NUM_M) : 1;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int TOP_LVL = NUM_LVL - 1;

    arb_state_t       state_q, state_d;
    logic [NUM_M-1:0] grant_q;
    logic [IW-1:0]    ptr_lo_q, ptr_hi_q;

    logic             contended;
    logic [NUM_M-1:0] holder;
    logic [NUM_M-1:0] cand;

    logic [NUM_LVL-1:0] lvl_found;
    logic [IW-1:0]      lvl_idx [NUM_LVL];
    logic [NUM_M-1:0]   lvl_mask [NUM_LVL];

    logic               win_found;
    logic [IW-1:0]      win_idx;
    logic [LVL_W-1:0]   win_lvl;
    logic [NUM_M-1:0]   win_onehot;

    // Holder exclusion applies only when more than one master contends
    assign contended = ($countones(req) > 1);
    assign holder    = (state_q == ST_OWNED) ? grant_q : '0;
    assign cand      = contended ? (req & ~holder) : req;

    // One candidate mask and one picker per level
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar m = 0; m < NUM_M; m++) begin : g_m
            assign lvl_mask[l][m] = cand[m] &&
                (level_vec[m*LVL_W +: LVL_W] == LVL_W'(l));
        end
        if (l == 0) begin : g_rr_lo
            arb_rr_pick #(.N(NUM_M), .IW(IW)) u_pick (
                .cand (lvl_mask[l]),
                .last (ptr_lo_q),
                .found(lvl_found[l]),
                .idx  (lvl_idx[l])
            );
        end else if (l == TOP_LVL) begin : g_rr_hi
            arb_rr_pick #(.N(NUM_M), .IW(IW)) u_pick (
                .cand (lvl_mask[l]),
                .last (ptr_hi_q),
                .found(lvl_found[l]),
                .idx  (lvl_idx[l])
            );
        end else begin : g_fix
            arb_fixed_pick #(.N(NUM_M), .IW(IW)) u_pick (
                .cand (lvl_mask[l]),
                .found(lvl_found[l]),
                .idx  (lvl_idx[l])
            );
        end
    end

    // Highest non-empty level wins
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_found[l]) begin
                win_found = 1'b1;
                win_idx   = lvl_idx[l];
                win_lvl   = l[LVL_W-1:0];
            end
        end
    end

    assign win_onehot = NUM_M'(1) << win_idx;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arb_point && win_found)  state_d = ST_OWNED;
            ST_OWNED: if (arb_point && !win_found) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and pool pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q  <= '0;
            ptr_lo_q <= IW'(NUM_M - 1);
            ptr_hi_q <= IW'(NUM_M - 1);
        end else if (arb_point) begin
            grant_q <= win_found ? win_onehot : '0;
            if (win_found && win_lvl == '0)
                ptr_lo_q <= win_idx;
            if (win_found && win_lvl == LVL_W'(TOP_LVL))
                ptr_hi_q <= win_idx;
        end
    end

    assign grant = grant_q;

    // R1: never more than one grant bit
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: no change without an arbitration point
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_point |=> $stable(grant));

    // R3: grant only to a master that requested
    a_r3_requested: assert property (@(posedge clk) disable iff (!rst_n)
        arb_point |=> (grant & ~$past(req)) == '0);

    // R8: contended holder is not re-granted
    a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && $countones(req) > 1 && grant != '0)
        |=> grant != $past(grant));

    // R9: sole requester keeps the grant
    a_r9_sole_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_point && $countones(req) == 1) |=> grant == $past(req));

    // R1: state and grant agree
    a_r1_state_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED) == (grant != '0));
endmodule

// File: tb/prio_pool_arbiter_bench.sv
module prio_pool_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [7:0] level_vec = '0;
    logic       arb_point = 1'b0;
    logic [3:0] grant;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int cur = -1;
    int ptr_lo = 3;
    int ptr_hi = 3;
    logic [3:0] exp_grant = '0;
    string exp_tag = "R1";

    always #5 clk = ~clk;

    prio_pool_arbiter u_prio_pool_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .level_vec(level_vec),
        .arb_point(arb_point), .grant(grant)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grant actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic int lvl_of(input logic [7:0] lv, input int m);
        return int'(lv[2*m +: 2]);
    endfunction

    // Compare last expectation, then apply inputs and advance the model
    task automatic step(input logic [3:0] r, input logic [7:0] lv, input bit ap, input string force_tag);
        int n, win, best, lo_cnt, l;
        bit elig [4];
        @(negedge clk);
        check(exp_tag, grant, exp_grant);
        req = r; level_vec = lv; arb_point = ap;
        if (!ap) begin
            exp_tag = (force_tag != "") ? force_tag : "R2";
            return;
        end
        n = 0;
        for (int i = 0; i < 4; i++) if (r[i]) n++;
        for (int i = 0; i < 4; i++) elig[i] = r[i] && !(n >= 2 && cur == i);
        best = -1; lo_cnt = 0;
        for (int i = 0; i < 4; i++) if (elig[i]) begin
            if (lvl_of(lv, i) > best) best = lvl_of(lv, i);
        end
        for (int i = 0; i < 4; i++) if (elig[i] && lvl_of(lv, i) < best) lo_cnt++;
        win = -1;
        if (best == 0 || best == 3) begin
            int p;
            p = (best == 0) ? ptr_lo : ptr_hi;
            for (int k = 1; k <= 4; k++) begin
                int j;
                j = (p + k) % 4;
                if (win < 0 && elig[j] && lvl_of(lv, j) == best) win = j;
            end
            if (win >= 0) begin
                if (best == 0) ptr_lo = win; else ptr_hi = win;
            end
        end else if (best > 0) begin
            for (int j = 0; j < 4; j++)
                if (win < 0 && elig[j] && lvl_of(lv, j) == best) win = j;
        end
        l = best;
        if (force_tag != "") exp_tag = force_tag;
        else if (n == 0) exp_tag = "R3";
        else if (n == 1) exp_tag = "R9";
        else if (lo_cnt > 0) exp_tag = "R4";
        else if (cur >= 0 && r[cur]) exp_tag = "R8";
        else if (l == 0) exp_tag = "R5";
        else if (l == 3) exp_tag = "R6";
        else exp_tag = "R7";
        cur = win;
        exp_grant = (win >= 0) ? (4'b1 << win) : 4'b0;
    endtask

    initial begin
        int wait_cnt [4];
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", grant, 4'b0);
        rst_n = 1'b1;
        // R5: plain round-robin after reset, all levels 0
        for (int c = 0; c < 6; c++) step(4'b1111, 8'h00, 1'b1, "R5");
        // R2: hold without arb point while requests change
        step(4'b0110, 8'h00, 1'b0, "R2");
        step(4'b1001, 8'h00, 1'b0, "R2");
        // R9: sole requester back to back
        step(4'b0100, 8'h00, 1'b1, "R9");
        step(4'b0100, 8'h00, 1'b1, "R9");
        step(4'b0100, 8'h00, 1'b1, "R9");
        // R3: no request clears grant
        step(4'b0000, 8'h00, 1'b1, "R3");
        step(4'b0000, 8'h00, 1'b1, "R3");
        // R7: level 2 masters 1 and 3, level 1 master 0
        step(4'b1011, 8'b10_00_10_01, 1'b1, "R7");
        step(4'b1011, 8'b10_00_10_01, 1'b1, "R8");
        step(4'b1011, 8'b10_00_10_01, 1'b1, "R8");
        // R10: raise master 0 to level 3 without arb point, then arbitrate
        step(4'b0011, 8'b00_00_00_00, 1'b1, "R5");
        step(4'b0011, 8'b00_00_00_11, 1'b0, "R10");
        step(4'b0011, 8'b00_00_00_11, 1'b1, "R10");
        // R4: level 3 beats others when not excluded
        step(4'b1110, 8'b01_10_11_00, 1'b1, "R4");
        // R6 and R11: three level-3 masters, continuous
        for (int i = 0; i < 4; i++) wait_cnt[i] = 0;
        for (int c = 0; c < 12; c++) begin
            step(4'b1111, 8'b11_00_11_11, 1'b1, "R6");
            @(negedge clk);
            #1;
            for (int i = 0; i < 4; i++) begin
                if (i == 2) continue;
                if (grant[i]) wait_cnt[i] = 0; else wait_cnt[i]++;
                if (c >= 3) begin
                    checks++;
                    if (wait_cnt[i] >= 3) begin
                        errors++;
                        $display("FAIL R11: master %0d waited %0d expected < 3", i, wait_cnt[i]);
                    end
                end
            end
            // this consumed a cycle with arb_point high: hold model in sync
            arb_point = 1'b0;
            exp_tag = "R2";
            @(posedge clk);
            #1;
        end
        // random mix
        for (int c = 0; c < 3000; c++) begin
            logic [7:0] lv;
            lv = ($urandom % 8 == 0) ? 8'($urandom) : level_vec;
            step(4'($urandom), lv, ($urandom % 3) != 0, "");
        end
        step(4'b0000, level_vec, 1'b0, "");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule